// File: doc/BRIEF.md
# General-purpose I/O port with atomic bit operations

This block is a port of general-purpose I/O pins (32 by default) whose registers sit on a simple memory-mapped register bus. Software uses it to drive output pins, choose each pin's direction and sample the pins' input levels. Besides a plain write to the output data register, it has three write-only mask registers. A write to one of them sets, clears or inverts only the selected output bits in a single bus cycle, so no read-modify-write sequence is ever needed.

The port has several independent write ports, two by default, that can write in the same cycle. A typical pairing is a general register bus and a single-cycle core-local path. Within one cycle, all writes are merged in a fixed order. Reads are combinational on a single read address. The input level register lags the pins by the synchronizer depth.

Register offsets, in words: 0 output data (read/write), 1 direction (read/write), 2 pin levels (read-only), 3 set mask, 4 clear mask, 5 invert mask. Offsets 3 to 5 are write-only.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and right after it is released, the output data register and the direction register are 0. All `pin_oe` bits are 0 and all `pin_out` bits are 0.
- R2: A write to offset 0 replaces the output data register with the write data. The new value is visible on the read port and on the pins from the cycle after the write.
- R3: A write to offset 3 forces each output data bit whose mask bit is 1 to 1 and leaves every other bit unchanged.
- R4: A write to offset 4 forces each output data bit whose mask bit is 1 to 0 and leaves every other bit unchanged.
- R5: A write to offset 5 inverts each output data bit whose mask bit is 1 and leaves every other bit unchanged.
- R6: Writes that land in the same cycle are applied in this order: direct data write, then set, then clear, then invert. If several ports write offset 0 (or offset 1) in one cycle, the highest-numbered port wins.
- R7: A write to offset 1 loads the direction register, where 1 means output and 0 means input. Bit n of the direction register drives `pin_oe[n]`.
- R8: `pin_out[n]` equals bit n of the output data register while pin n is an output, and is 0 while pin n is an input.
- R9: Reading offset 2 returns `pin_in` as it was sampled two clock edges earlier (two-flop synchronizer), with bit n for pin n.
- R10: Offsets 3, 4, 5 and the unmapped offsets 6 and 7 read as 0. Writes to offset 2, 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | NUM_WR_PORTS | Write strobe, one per write port |
| wr_addr | input | NUM_WR_PORTS*3 | Word offset per write port, port p at bits [3p+2:3p] |
| wr_data | input | NUM_WR_PORTS*PIN_W | Write data per write port, port p at bits [PIN_W*(p+1)-1:PIN_W*p] |
| rd_addr | input | 3 | Read word offset |
| rd_data | output | PIN_W | Combinational read data |
| pin_in | input | PIN_W | Pad input levels |
| pin_out | output | PIN_W | Pad output levels |
| pin_oe | output | PIN_W | Pad output enables |

## Verification
Two write ports can hit the output data register in the same cycle, for example a set from one port and a clear or invert from the other, or two direct data writes. Directed dual writes are chosen so that every other merge order would give a different result. One example is a set and an invert on the same bit, which must end at 0. A random phase then drives both ports with arbitrary offsets every cycle. A behavioural model that applies the stated order is compared with the pins and the read data after every clock edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      OFS_DATA = 3'd0,
      OFS_DIR  = 3'd1,
      OFS_PINS = 3'd2,
      OFS_SET  = 3'd3,
      OFS_CLR  = 3'd4,
      OFS_TGL  = 3'd5
   } reg_ofs_e;
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
   import gpio_port_pkg::*;
#(
   parameter int PIN_W = 32,
   parameter int NUM_WR_PORTS = 2
) (
   input  logic [NUM_WR_PORTS-1:0]        wr_en,
   input  logic [NUM_WR_PORTS*REG_AW-1:0] wr_addr,
   input  logic [NUM_WR_PORTS*PIN_W-1:0]  wr_data,
   output logic                           data_we,
   output logic [PIN_W-1:0]               data_val,
   output logic                           dir_we,
   output logic [PIN_W-1:0]               dir_val,
   output logic [PIN_W-1:0]               set_m,
   output logic [PIN_W-1:0]               clr_m,
   output logic [PIN_W-1:0]               tgl_m
);
   logic [REG_AW-1:0] port_a [NUM_WR_PORTS];
   logic [PIN_W-1:0]  port_d [NUM_WR_PORTS];

   for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_slice
      assign port_a[p] = wr_addr[p*REG_AW +: REG_AW];
      assign port_d[p] = wr_data[p*PIN_W +: PIN_W];
   end

   // Later ports override earlier ones for full-register writes; masks merge.
   always_comb begin
      data_we  = 1'b0;
      data_val = '0;
      dir_we   = 1'b0;
      dir_val  = '0;
      set_m    = '0;
      clr_m    = '0;
      tgl_m    = '0;
      for (int p = 0; p < NUM_WR_PORTS; p++) begin
         if (wr_en[p]) begin
            case (port_a[p])
               OFS_DATA: begin data_we = 1'b1; data_val = port_d[p]; end
               OFS_DIR:  begin dir_we  = 1'b1; dir_val  = port_d[p]; end
               OFS_SET:  set_m = set_m | port_d[p];
               OFS_CLR:  clr_m = clr_m | port_d[p];
               OFS_TGL:  tgl_m = tgl_m | port_d[p];
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_out_ctrl.sv
module gpio_out_ctrl #(
   parameter int PIN_W = 32,
   parameter bit GATE_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_we,
   input  logic [PIN_W-1:0] data_val,
   input  logic             dir_we,
   input  logic [PIN_W-1:0] dir_val,
   input  logic [PIN_W-1:0] set_m,
   input  logic [PIN_W-1:0] clr_m,
   input  logic [PIN_W-1:0] tgl_m,
   output logic [PIN_W-1:0] odr_q,
   output logic [PIN_W-1:0] dir_q,
   output logic [PIN_W-1:0] pin_out,
   output logic [PIN_W-1:0] pin_oe
);
   logic [PIN_W-1:0] odr_base, odr_after_set, odr_after_clr, odr_nxt;

   // Fixed merge order: data, set, clear, invert.
   always_comb begin
      odr_base      = data_we ? data_val : odr_q;
      odr_after_set = odr_base | set_m;
      odr_after_clr = odr_after_set & ~clr_m;
      odr_nxt       = odr_after_clr ^ tgl_m;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odr_q <= '0;
         dir_q <= '0;
      end else begin
         odr_q <= odr_nxt;
         if (dir_we) dir_q <= dir_val;
      end
   end

   assign pin_oe = dir_q;

   if (GATE_OUT) begin : g_gated
      assign pin_out = odr_q & dir_q;
   end else begin : g_raw
      assign pin_out = odr_q;
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int PIN_W = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pins_async,
   output logic [PIN_W-1:0] pins_sync
);
   logic [PIN_W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pins_async;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign pins_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int PIN_W = 32,
   parameter int NUM_WR_PORTS = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_OUT = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_WR_PORTS-1:0]        wr_en,
   input  logic [NUM_WR_PORTS*REG_AW-1:0] wr_addr,
   input  logic [NUM_WR_PORTS*PIN_W-1:0]  wr_data,
   input  logic [REG_AW-1:0]              rd_addr,
   output logic [PIN_W-1:0]               rd_data,
   input  logic [PIN_W-1:0]               pin_in,
   output logic [PIN_W-1:0]               pin_out,
   output logic [PIN_W-1:0]               pin_oe
);
   if (PIN_W < 1 || PIN_W > 64) begin : g_bad_width
      $error("gpio_port: PIN_W out of range");
   end
   if (NUM_WR_PORTS < 1) begin : g_bad_ports
      $error("gpio_port: needs at least one write port");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: synchronizer needs two or more stages");
   end

   logic             data_we, dir_we;
   logic [PIN_W-1:0] data_val, dir_val, set_m, clr_m, tgl_m;
   logic [PIN_W-1:0] odr_q, dir_q, pins_sync;

   gpio_wr_decode #(.PIN_W(PIN_W), .NUM_WR_PORTS(NUM_WR_PORTS)) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .data_we(data_we), .data_val(data_val),
      .dir_we(dir_we), .dir_val(dir_val),
      .set_m(set_m), .clr_m(clr_m), .tgl_m(tgl_m)
   );

   gpio_out_ctrl #(.PIN_W(PIN_W), .GATE_OUT(GATE_OUT)) u_out (
      .clk(clk), .rst_n(rst_n),
      .data_we(data_we), .data_val(data_val),
      .dir_we(dir_we), .dir_val(dir_val),
      .set_m(set_m), .clr_m(clr_m), .tgl_m(tgl_m),
      .odr_q(odr_q), .dir_q(dir_q),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .pins_async(pin_in), .pins_sync(pins_sync)
   );

   always_comb begin
      case (rd_addr)
         OFS_DATA: rd_data = odr_q;
         OFS_DIR:  rd_data = dir_q;
         OFS_PINS: rd_data = pins_sync;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
   import gpio_port_pkg::*;
#(
   parameter int PIN_W = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit GATE_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              solo0,
   input logic [REG_AW-1:0] p0_addr,
   input logic [PIN_W-1:0]  p0_data,
   input logic [REG_AW-1:0] rd_addr,
   input logic [PIN_W-1:0]  rd_data,
   input logic [PIN_W-1:0]  pin_in,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe,
   input logic [PIN_W-1:0]  odr_q
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (solo0 && p0_addr == OFS_SET) |=> ((odr_q & $past(p0_data)) == $past(p0_data)));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (solo0 && p0_addr == OFS_CLR) |=> ((odr_q & $past(p0_data)) == '0));

   p_invert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (solo0 && p0_addr == OFS_TGL && cyc != 2'd0) |=> (odr_q == $past(odr_q ^ p0_data)));

   p_dir_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (solo0 && p0_addr == OFS_DIR) |=> (pin_oe == $past(p0_data)));

   p_alias_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == OFS_SET || rd_addr == OFS_CLR || rd_addr == OFS_TGL) |-> (rd_data == '0));

   if (GATE_OUT) begin : g_gate_chk
      p_out_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ((pin_out & ~pin_oe) == '0));
   end

   if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_addr == OFS_PINS && cyc >= 2'd2) |-> (rd_data == $past(pin_in, 2)));
   end
endmodule

bind gpio_port gpio_port_chk #(
   .PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES), .GATE_OUT(GATE_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .solo0(wr_en == NUM_WR_PORTS'(1)),
   .p0_addr(wr_addr[2:0]),
   .p0_data(wr_data[PIN_W-1:0]),
   .rd_addr(rd_addr), .rd_data(rd_data),
   .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
   .odr_q(odr_q)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
   localparam int W = 32;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] wr_en = '0;
   logic [NP*3-1:0] wr_addr = '0;
   logic [NP*W-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [W-1:0]  rd_data, pin_out, pin_oe;
   logic [W-1:0]  pin_in = '0;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   gpio_port #(.PIN_W(W), .NUM_WR_PORTS(NP), .SYNC_STAGES(2), .GATE_OUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [W-1:0] m_out = '0;
   logic [W-1:0] m_dir = '0;
   logic [W-1:0] hist[$] = '{32'h0, 32'h0};

   function automatic logic [W-1:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_out;
         3'd1: return m_dir;
         3'd2: return hist[1];
         default: return '0;
      endcase
   endfunction

   always begin
      @(posedge clk);
      if (!rst_n) begin
         m_out = '0; m_dir = '0; hist = '{32'h0, 32'h0};
      end else begin
         logic [W-1:0] base, s, c, t;
         base = m_out; s = '0; c = '0; t = '0;
         for (int p = 0; p < NP; p++) begin
            if (wr_en[p]) begin
               case (wr_addr[p*3 +: 3])
                  3'd0: base = wr_data[p*W +: W];
                  3'd1: m_dir = wr_data[p*W +: W];
                  3'd3: s = s | wr_data[p*W +: W];
                  3'd4: c = c | wr_data[p*W +: W];
                  3'd5: t = t | wr_data[p*W +: W];
                  default: ;
               endcase
            end
         end
         m_out = ((base | s) & ~c) ^ t;
         hist.push_front(pin_in);
         hist = hist[0:1];
      end
      #1;
      chk("R7 pin_oe", pin_oe, m_dir);
      chk("R8 pin_out", pin_out, m_out & m_dir);
      if (rd_addr == 3'd2) chk("R9 input readback", rd_data, m_read(rd_addr));
      else if (rd_addr >= 3'd3) chk("R10 alias/unmapped read", rd_data, '0);
      else chk("R2 register readback", rd_data, m_read(rd_addr));
   end

   task automatic wr1(input int p, input logic [2:0] a, input logic [W-1:0] d);
      wr_en = '0;
      wr_en[p] = 1'b1;
      wr_addr[p*3 +: 3] = a;
      wr_data[p*W +: W] = d;
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic wr2(input logic [2:0] a0, input logic [W-1:0] d0,
                      input logic [2:0] a1, input logic [W-1:0] d1);
      wr_en = 2'b11;
      wr_addr = {a1, a0};
      wr_data = {d1, d0};
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [W-1:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   initial begin
      #600000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", pin_oe, '0);
      chk("R1 out in reset", pin_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R1 data after reset", 3'd0, '0);
      rd_chk("R1 dir after reset", 3'd1, '0);

      wr1(0, 3'd1, 32'hFFFF_FFFF);
      chk("R7 all outputs", pin_oe, 32'hFFFF_FFFF);
      wr1(1, 3'd0, 32'h0000_FFFF);
      chk("R2 data write", pin_out, 32'h0000_FFFF);
      wr1(0, 3'd3, 32'hF000_0000);
      rd_chk("R3 set", 3'd0, 32'hF000_FFFF);
      wr1(1, 3'd4, 32'h0000_00FF);
      rd_chk("R4 clear", 3'd0, 32'hF000_FF00);
      wr1(0, 3'd5, 32'hFF00_00FF);
      rd_chk("R5 invert", 3'd0, 32'h0F00_FFFF);

      rd_chk("R10 set reads zero", 3'd3, '0);
      rd_chk("R10 invert reads zero", 3'd5, '0);
      wr1(0, 3'd2, 32'hDEAD_BEEF);
      wr1(1, 3'd7, 32'h1234_5678);
      rd_chk("R10 ignored writes data", 3'd0, 32'h0F00_FFFF);
      rd_chk("R10 ignored writes dir", 3'd1, 32'hFFFF_FFFF);

      wr2(3'd3, 32'h0000_0003, 3'd4, 32'h0000_0001);
      rd_chk("R6 set then clear", 3'd0, 32'h0F00_FFFE);
      wr2(3'd5, 32'h0001_0000, 3'd3, 32'h0001_0000);
      rd_chk("R6 set then invert", 3'd0, 32'h0F00_FFFE);
      wr2(3'd0, 32'h1234_5678, 3'd4, 32'h0000_000F);
      rd_chk("R6 data then clear", 3'd0, 32'h1234_5670);
      wr2(3'd0, 32'h0000_0001, 3'd0, 32'h0000_0002);
      rd_chk("R6 highest port wins", 3'd0, 32'h0000_0002);

      wr1(1, 3'd1, 32'h0000_FFFF);
      chk("R7 partial dir", pin_oe, 32'h0000_FFFF);
      wr1(0, 3'd0, 32'hFFFF_0000);
      chk("R8 inputs not driven", pin_out, '0);
      rd_chk("R8 data kept", 3'd0, 32'hFFFF_0000);

      pin_in = 32'hCAFE_BABE;
      rd_chk("R9 before lag", 3'd2, '0);
      @(negedge clk);
      rd_chk("R9 one edge", 3'd2, '0);
      @(negedge clk);
      rd_chk("R9 two edges", 3'd2, 32'hCAFE_BABE);

      for (int i = 0; i < 3000; i++) begin
         wr_en   = 2'($urandom);
         wr_addr = 6'($urandom);
         wr_data = {$urandom, $urandom};
         rd_addr = 3'($urandom);
         pin_in  = $urandom;
         @(negedge clk);
      end
      wr_en = '0;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule